// File: doc/BRIEF.md
# Software-Triggered Parallel LCD Frame Writer

This block pushes one frame of pixel words onto an 8080-style parallel LCD write bus. Software arms it through a small register port: a trigger control byte holds a trigger-enable bit, a write-only start command and a read-only frame-done flag. A separate timing word holds two 4-bit setup counts, one for the gap from the address/register-select line to chip select and one for the gap from chip select to the write strobe.

Once started, the controller takes one pixel word per bus write from a valid/ready source. For each word it raises the address line, then pulls chip select low, then pulses the write strobe low for one cycle while the word is on the data pins. It releases the strobes in reverse order. If the source has no data, the bus waits with every strobe inactive. After the programmed number of words the controller returns to idle and sets the done flag. The flag clears when software reads the trigger register or when the next frame starts.

Top module: `lcd_frame_trigger`

## Requirements
- R1: After reset both registers read 0, `lcd_rs` is 0, `lcd_cs_n` is 1, `lcd_wr_n` is 1 and `pix_ready` is 0.
- R2: Trigger register (`reg_sel`=0) layout:
  - bit 0 is the trigger enable and reads back as written.
  - bit 1 always reads 0.
  - bit 2 reads the done flag ANDed with bit 0.
  - bits 31:3 read 0, and any value written to bits 7:3 has no effect.
- R3: Writing the trigger register with bit 0 = 1 and bit 1 = 1 while idle starts a frame. A write with bit 1 = 1 and bit 0 = 0 starts nothing.
- R4: Timing register (`reg_sel`=1) layout:
  - bits 19:16 hold the CS setup count C.
  - bits 15:12 hold the WR setup count W.
  - all other bits read 0.
- R5: For each word, `lcd_rs` is high with `lcd_cs_n` still high for exactly C cycles before `lcd_cs_n` falls. With C = 0, both change in the same cycle.
- R6: `lcd_cs_n` is low with `lcd_wr_n` still high for exactly W cycles before `lcd_wr_n` falls. With W = 0, both change in the same cycle.
- R7: Strobe shape for each word:
  - `lcd_wr_n` is low for exactly one cycle, with the current pixel word on `lcd_data`.
  - `lcd_cs_n` rises one cycle after `lcd_wr_n` rises.
  - `lcd_rs` falls one cycle after `lcd_cs_n` rises.
- R8: A frame of N = `frame_len` words (N > 0) produces exactly N write strobes. The bus then stays idle, and the done flag reads 1.
- R9: The done flag reads 0 from the cycle after a trigger-register read (`reg_rd_en` with `reg_sel`=0). It also reads 0 from the cycle after an accepted start.
- R10: A start command written while a frame is in progress is ignored. The frame still ends after N words, and no further frame follows.
- R11: Source handshake:
  - `pix_ready` is high only during the write-strobe cycle, so exactly one word is consumed per write.
  - While `pix_valid` is low between words, `lcd_rs` stays 0 and `lcd_cs_n` stays 1.
- R12: A start with `frame_len` = 0 sets the done flag at once, with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clears done flag on trigger register) |
| reg_sel | input | 1 | 0 = trigger register, 1 = timing register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| frame_len | input | LEN_W | Pixel words per frame |
| pix_data | input | DATA_W | Pixel word from source |
| pix_valid | input | 1 | Source word available |
| pix_ready | output | 1 | Word consumed this cycle |
| lcd_rs | output | 1 | Address/register-select line, high when active |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_data | output | DATA_W | Bus data |

## Verification
An accepted start is seen on the next clock edge: at the next sample the bus is waiting for data, and the done flag already reads 0. If the source is valid, `lcd_rs` rises one cycle later. The strobe edges then follow every C, W, 1, 1, 1 cycles, and the done flag reads 1 in the cycle after `lcd_rs` falls on the last word. The bench samples every cycle on the falling clock edge and measures each phase length by counting cycles. It compares those lengths, and the data present at the write pulse, with values worked out from C, W, N and the stall length, over all C and W in 0..3. A read-clear is checked as the value during the read cycle followed by 0 in the next cycle.

// File: rtl/lcd_trig_pkg.sv
// Package: shared state encoding and register layout for the LCD frame writer.
// Assumes a 32-bit register data path.
package lcd_trig_pkg;
    localparam int REG_W      = 32;
    localparam int SETUP_W    = 4;
    localparam int CS_LSB     = 16;
    localparam int WR_LSB     = 12;
    localparam int MODE_BIT   = 0;
    localparam int CMD_BIT    = 1;
    localparam int DONE_BIT   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CSU,
        ST_WSU,
        ST_STRB,
        ST_HOLD,
        ST_REL
    } seq_st_t;
endpackage

// File: rtl/lcd_trig_regs.sv
// Module: trigger/status and timing registers.
// Generates a one-cycle start pulse when an enabled start command is written
// while the sequencer is idle. Holds the done flag (set by frame finish,
// cleared by trigger-register read or start; set wins).
// Assumes reg_sel selects between exactly two registers.
module lcd_trig_regs
    import lcd_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               busy,
    input  logic               frame_fin,
    output logic               start,
    output logic [SETUP_W-1:0] cs_setup,
    output logic [SETUP_W-1:0] wr_setup
);
    logic mode_q;
    logic done_q;
    logic trig_wr;
    logic rd_clr;

    // Decode register accesses and the start command.
    always_comb begin
        trig_wr = reg_wr_en && (reg_sel == 1'b0);
        rd_clr  = reg_rd_en && (reg_sel == 1'b0);
        start   = trig_wr && reg_wdata[MODE_BIT] && reg_wdata[CMD_BIT] && !busy;
    end

    // Register state: mode, done flag and setup counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
            cs_setup <= '0;
            wr_setup <= '0;
        end else begin
            if (trig_wr)
                mode_q <= reg_wdata[MODE_BIT];
            if (reg_wr_en && reg_sel) begin
                cs_setup <= reg_wdata[CS_LSB +: SETUP_W];
                wr_setup <= reg_wdata[WR_LSB +: SETUP_W];
            end
            if (frame_fin)
                done_q <= 1'b1;
            else if (start || rd_clr)
                done_q <= 1'b0;
        end
    end

    // Read mux; reserved and write-only bits read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel == 1'b0) begin
            reg_rdata[MODE_BIT] = mode_q;
            reg_rdata[DONE_BIT] = done_q & mode_q;
        end else begin
            reg_rdata[CS_LSB +: SETUP_W] = cs_setup;
            reg_rdata[WR_LSB +: SETUP_W] = wr_setup;
        end
    end

    // A read clear without a simultaneous finish leaves the flag low.
    assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !frame_fin) |=> !done_q);
    // A start while busy never reaches the sequencer.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig_wr) |-> !start);
endmodule

// File: rtl/lcd_strobe_seq.sv
// Module: per-word strobe sequencer and word counter.
// Assumes setup counts and frame_len are stable while a frame runs and that
// the source holds pix_valid and pix_data until pix_ready.
module lcd_strobe_seq
    import lcd_trig_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic [SETUP_W-1:0] cs_setup,
    input  logic [SETUP_W-1:0] wr_setup,
    input  logic [DATA_W-1:0]  pix_data,
    input  logic               pix_valid,
    output logic               pix_ready,
    output logic               bus_rs,
    output logic               bus_cs_n,
    output logic               bus_wr_n,
    output logic [DATA_W-1:0]  bus_data,
    output logic               busy,
    output logic               frame_fin
);
    seq_st_t            state;
    logic [SETUP_W-1:0] cnt;
    logic [LEN_W-1:0]   left;

    // Main sequencer: setup countdowns, strobe, release, word counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            left     <= '0;
            bus_data <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start && frame_len != '0) begin
                    state <= ST_WAIT;
                    left  <= frame_len;
                end
                ST_WAIT: if (pix_valid) begin
                    bus_data <= pix_data;
                    if (cs_setup != '0) begin
                        state <= ST_CSU;
                        cnt   <= cs_setup;
                    end else if (wr_setup != '0) begin
                        state <= ST_WSU;
                        cnt   <= wr_setup;
                    end else begin
                        state <= ST_STRB;
                    end
                end
                ST_CSU: if (cnt == SETUP_W'(1)) begin
                    if (wr_setup != '0) begin
                        state <= ST_WSU;
                        cnt   <= wr_setup;
                    end else begin
                        state <= ST_STRB;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_WSU: if (cnt == SETUP_W'(1)) state <= ST_STRB;
                        else cnt <= cnt - 1'b1;
                ST_STRB: begin
                    state <= ST_HOLD;
                    left  <= left - 1'b1;
                end
                ST_HOLD: state <= ST_REL;
                ST_REL:  state <= (left == '0) ? ST_IDLE : ST_WAIT;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe decode from state.
    always_comb begin
        bus_rs    = (state == ST_CSU) || (state == ST_WSU) || (state == ST_STRB) ||
                    (state == ST_HOLD) || (state == ST_REL);
        bus_cs_n  = !((state == ST_WSU) || (state == ST_STRB) || (state == ST_HOLD));
        bus_wr_n  = (state != ST_STRB);
        pix_ready = (state == ST_STRB);
        busy      = (state != ST_IDLE);
        frame_fin = ((state == ST_REL) && (left == '0)) ||
                    ((state == ST_IDLE) && start && (frame_len == '0));
    end

    // Chip select only inside an active address phase.
    assert_cs_in_rs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> bus_rs);
    // Write strobe only inside chip select.
    assert_wr_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (!bus_cs_n && bus_rs));
    // Write strobe is a single-cycle pulse followed by CS still low.
    assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |=> (bus_wr_n && !bus_cs_n));
    // A word is taken only when offered.
    assert_consume_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> pix_valid);
    // The frame counter never wraps: a finish returns to idle.
    assert_finish_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_fin && busy) |=> !busy);
endmodule

// File: rtl/lcd_frame_trigger.sv
// Module: top of the software-triggered LCD frame writer.
// Connects the register block to the strobe sequencer. Assumes a single
// panel port and that software keeps timing fields stable during a frame.
module lcd_frame_trigger
    import lcd_trig_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    output logic              lcd_rs,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data
);
    logic               start;
    logic               busy;
    logic               frame_fin;
    logic [SETUP_W-1:0] cs_setup;
    logic [SETUP_W-1:0] wr_setup;

    lcd_trig_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .frame_fin (frame_fin),
        .start     (start),
        .cs_setup  (cs_setup),
        .wr_setup  (wr_setup)
    );

    lcd_strobe_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frame_len (frame_len),
        .cs_setup  (cs_setup),
        .wr_setup  (wr_setup),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .bus_rs    (lcd_rs),
        .bus_cs_n  (lcd_cs_n),
        .bus_wr_n  (lcd_wr_n),
        .bus_data  (lcd_data),
        .busy      (busy),
        .frame_fin (frame_fin)
    );
endmodule

// File: tb/lcd_frame_trigger_tb_top.sv
module lcd_frame_trigger_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  frame_len = 8'd0;
    logic [15:0] pix_data;
    logic        pix_valid;
    logic        pix_ready;
    logic        lcd_rs, lcd_cs_n, lcd_wr_n;
    logic [15:0] lcd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int src_idx = 0;
    int hold_cnt = 0;
    int hold_k = 0;
    logic src_on = 1'b0;

    always #5 clk = ~clk;

    lcd_frame_trigger dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_len(frame_len), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .lcd_rs(lcd_rs), .lcd_cs_n(lcd_cs_n),
        .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data)
    );

    function automatic logic [15:0] pix_fn(int i);
        return 16'(i * 291 + 16'h5A00);
    endfunction

    // Pixel source: advances on handshake, optionally stalls hold_k cycles.
    assign pix_data  = pix_fn(src_idx);
    assign pix_valid = src_on && (hold_cnt == 0);
    always @(posedge clk) begin
        if (pix_valid && pix_ready) begin
            src_idx  <= src_idx + 1;
            hold_cnt <= hold_k;
        end else if (hold_cnt > 0) begin
            hold_cnt <= hold_cnt - 1;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(logic sel, logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        step();
        reg_wr_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic idle_check(int cycles, string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            if (lcd_rs || !lcd_cs_n || !lcd_wr_n) bad++;
            step();
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Run one frame and measure every phase of every word.
    task automatic run_frame(int c, int w, int n, int k, bit busy_trig);
        int base;
        int gap, n1, n2, g;
        reg_write(1'b1, (32'(c) << 16) | (32'(w) << 12));
        frame_len = 8'(n);
        hold_k = k;
        base = src_idx;
        reg_write(1'b0, 32'h3);
        chk(reg_rdata[2] == 1'b0, "R9 done cleared by start", reg_rdata[2], 0);
        if (busy_trig) fork
            begin
                repeat (5) step();
                reg_wdata = 32'h3; reg_wr_en = 1'b1;
                step();
                reg_wr_en = 1'b0;
            end
        join_none
        for (int wd = 0; wd < n; wd++) begin
            gap = 0; g = 0;
            while (!lcd_rs && g < 100) begin
                chk(lcd_cs_n && lcd_wr_n, "R11 idle strobes while waiting", lcd_cs_n, 1);
                gap++; g++; step();
            end
            if (wd > 0)
                chk(gap == ((k >= 2) ? k - 1 : 1), "R11 inter-word gap", gap, (k >= 2) ? k - 1 : 1);
            n1 = 0;
            while (lcd_rs && lcd_cs_n && n1 < 40) begin n1++; step(); end
            chk(n1 == c, "R5 rs-to-cs setup", n1, c);
            n2 = 0;
            while (!lcd_cs_n && lcd_wr_n && n2 < 40) begin n2++; step(); end
            chk(n2 == w, "R6 cs-to-wr setup", n2, w);
            chk(!lcd_wr_n && pix_ready, "R11 ready with strobe", pix_ready, 1);
            chk(lcd_data == pix_fn(base + wd), "R7 data at strobe", lcd_data, pix_fn(base + wd));
            step();
            chk(lcd_wr_n && !lcd_cs_n && !pix_ready, "R7 wr released first", lcd_cs_n, 0);
            step();
            chk(lcd_cs_n && lcd_rs, "R7 cs released before rs", lcd_rs, 1);
            step();
            chk(!lcd_rs, "R7 rs released last", lcd_rs, 0);
        end
        chk(reg_rdata[2] == 1'b1, "R8 done after last word", reg_rdata[2], 1);
        idle_check(15, busy_trig ? "R10 no extra frame" : "R8 idle after frame");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk(reg_rdata == 32'h0, "R1 trigger reg reset", reg_rdata, 0);
        reg_sel = 1'b1; #1;
        chk(reg_rdata == 32'h0, "R1 timing reg reset", reg_rdata, 0);
        reg_sel = 1'b0; #1;
        chk(!lcd_rs && lcd_cs_n && lcd_wr_n && !pix_ready, "R1 bus idle", lcd_rs, 0);
        src_on = 1'b1;

        // R2 reserved bits ignored, mode readback
        reg_write(1'b0, 32'hF9);
        chk(reg_rdata == 32'h1, "R2 reserved ignored", reg_rdata, 1);
        // R3 command without enable does nothing
        reg_write(1'b0, 32'h2);
        chk(reg_rdata == 32'h0, "R2 cmd bit reads 0", reg_rdata, 0);
        idle_check(15, "R3 no start when disabled");
        // R4 timing readback
        reg_write(1'b1, 32'hFFFF_FFFF);
        reg_sel = 1'b1; #1;
        chk(reg_rdata == 32'h000F_F000, "R4 timing fields", reg_rdata, 32'h000F_F000);
        reg_sel = 1'b0;

        // R3/R5/R6/R7/R8 sweep of setup counts
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 4; w++)
                run_frame(c, w, 3, 0, 1'b0);

        // R2 done masked by mode, R9 read clear
        reg_write(1'b0, 32'h0);
        chk(reg_rdata[2] == 1'b0, "R2 done masked by mode", reg_rdata[2], 0);
        reg_write(1'b0, 32'h1);
        chk(reg_rdata[2] == 1'b1, "R2 done shown with mode", reg_rdata[2], 1);
        reg_rd_en = 1'b1; #1;
        chk(reg_rdata[2] == 1'b1, "R9 done during read", reg_rdata[2], 1);
        step();
        reg_rd_en = 1'b0; #1;
        chk(reg_rdata[2] == 1'b0, "R9 done cleared by read", reg_rdata[2], 0);

        // R11 stalls, R10 trigger while busy
        run_frame(2, 1, 4, 4, 1'b0);
        run_frame(1, 2, 5, 0, 1'b1);

        // R12 zero-length frame
        reg_rd_en = 1'b1; step(); reg_rd_en = 1'b0;
        frame_len = 8'd0;
        reg_write(1'b0, 32'h3);
        chk(reg_rdata == 32'h5, "R12 done with zero length", reg_rdata, 5);
        idle_check(10, "R12 no bus activity");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule